// File: doc/BRIEF.md
# Remapping Frame Buffer for Multi-Converter Sample Capture

This block collects conversion results from eight converters of eight channels each, one sample per clock step, and assembles them into 64-channel frames. Each incoming word carries the converter number and the converter's channel number that produced it. A programmable lookup translates that physical position into a logical sensor channel, and the word is written into a dual-port frame memory at that sensor's slot. Stored frames therefore come out in true sensor order, however the board wiring scattered the channels across the converters.

The memory is a ring of complete frames. A frame becomes visible to the reader only once all 64 of its samples have been written. The reader is independent of the writer and moves whole frames, sensor 0 first, onto a valid/ready stream that feeds a host FIFO. The stream marks the final word of every frame. When the ring is full, a newly started frame is discarded as a whole. This raises a sticky overflow flag and increments a drop counter.

Ring depth defaults to 16 frames. Any power of two up to 512 frames is supported through a parameter.

Top module: `descramble_fbuf`

## Requirements
- R1: After reset, out_valid, overflow, frames_ready and drop_count are all 0, and the lookup is the identity (physical index p maps to sensor p).
- R2: The physical index of a sample is in_adc*8 + in_chan. A lookup write (map_we) sets entry map_idx to map_val only while acq_en is low. While acq_en is high the write has no effect.
- R3: A sample with physical index p is stored at the slot of sensor lookup[p] within the frame being filled.
- R4: frames_ready increments one cycle after the 64th accepted sample of a frame, and not before.
- R5: Each frame is streamed as 64 words in sensor order 0 to 63, with out_last high on sensor 63 only.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values, and no word is lost.
- R7: Frames are streamed in the order they completed, and the ring holds up to FRAMES frames.
- R8: A frame whose first sample arrives while frames_ready equals FRAMES is discarded entirely. On its 64th sample, overflow becomes 1 and stays 1 until reset, and drop_count increments by 1.
- R9: While acq_en is low, in_valid is ignored and any partly collected frame is abandoned. Collection restarts at a frame boundary.
- R10: When a frame completes in the same cycle as the reader fetches the last word of another frame, frames_ready stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition enable; low permits lookup writes |
| map_we | input | 1 | Lookup write strobe |
| map_idx | input | 6 | Physical index of the lookup entry to write |
| map_val | input | 6 | Sensor channel to store in that entry |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | DW (16) | Sample word |
| in_adc | input | 3 | Converter number of the sample |
| in_chan | input | 3 | Channel number within the converter |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW (16) | Output word |
| out_last | output | 1 | Word is sensor 63 of its frame |
| out_ready | input | 1 | Downstream accepts the word |
| frames_ready | output | 5 | Completed frames not yet fully fetched by the reader |
| overflow | output | 1 | Sticky: a frame has been dropped |
| drop_count | output | DCW (16) | Number of dropped frames, modulo 2^DCW |

## Verification
The critical coincidence is a frame being committed by the writer in the same cycle as the reader releases the slot of another frame. With samples arriving every cycle and out_ready held high, both events fall on the same edge for every frame after the first. The bench provokes this by streaming several frames back to back. It judges the result by requiring that frames_ready never exceeds 1, that no frame is dropped, and that every word matches the scoreboard. A second coincidence, stalls on the output while frames keep arriving, is driven with a toggling out_ready pattern. It is judged by the hold checks and by lossless scoreboard matching.

// File: rtl/descramble_fbuf.sv
module descramble_fbuf #(
  parameter int DW     = 16,
  parameter int ADCS   = 8,   // power of two
  parameter int CHS    = 8,   // power of two
  parameter int FRAMES = 16,  // power of two, at least 2
  parameter int DCW    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acq_en,
  input  logic                          map_we,
  input  logic [$clog2(ADCS*CHS)-1:0]   map_idx,
  input  logic [$clog2(ADCS*CHS)-1:0]   map_val,
  input  logic                          in_valid,
  input  logic [DW-1:0]                 in_data,
  input  logic [$clog2(ADCS)-1:0]       in_adc,
  input  logic [$clog2(CHS)-1:0]        in_chan,
  output logic                          out_valid,
  output logic [DW-1:0]                 out_data,
  output logic                          out_last,
  input  logic                          out_ready,
  output logic [$clog2(FRAMES+1)-1:0]   frames_ready,
  output logic                          overflow,
  output logic [DCW-1:0]                drop_count
);
  localparam int NCH   = ADCS * CHS;
  localparam int CW    = $clog2(NCH);
  localparam int FW    = $clog2(FRAMES);
  localparam int NW    = $clog2(FRAMES + 1);
  localparam int DEPTH = FRAMES * NCH;

  logic [CW-1:0] remap [NCH];
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wcnt, rch;
  logic [FW-1:0] wfrm, rfrm;
  logic [NW-1:0] fill;
  logic          dropping;

  wire [CW-1:0] sensor   = remap[{in_adc, in_chan}];
  wire          take     = acq_en & in_valid;
  wire          drop_now = (wcnt == '0) ? (fill == NW'(FRAMES)) : dropping;
  wire          wr_last  = take & (wcnt == CW'(NCH - 1));
  wire          commit   = wr_last & ~drop_now;
  wire          load     = ~out_valid | out_ready;
  wire          fetch    = load & (fill != '0);
  wire          drain    = fetch & (rch == CW'(NCH - 1));

  assign frames_ready = fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) remap[i] <= CW'(i);
    end else if (map_we && !acq_en) begin
      remap[map_idx] <= map_val;
    end
  end

  always_ff @(posedge clk)
    if (take && !drop_now) mem[{wfrm, sensor}] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt       <= '0;
      wfrm       <= '0;
      dropping   <= 1'b0;
      overflow   <= 1'b0;
      drop_count <= '0;
    end else if (!acq_en) begin
      wcnt     <= '0;
      dropping <= 1'b0;
    end else if (in_valid) begin
      wcnt     <= wcnt + CW'(1);
      dropping <= drop_now;
      if (commit) wfrm <= wfrm + FW'(1);
      if (wr_last && drop_now) begin
        overflow   <= 1'b1;
        drop_count <= drop_count + DCW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fill <= '0;
    else if (commit && !drain) fill <= fill + NW'(1);
    else if (drain && !commit) fill <= fill - NW'(1);
  end

  always_ff @(posedge clk)
    if (fetch) out_data <= mem[{rfrm, rch}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      rch       <= '0;
      rfrm      <= '0;
    end else if (load) begin
      out_valid <= fetch;
      out_last  <= drain;
      if (fetch) rch <= rch + CW'(1);
      if (drain) rfrm <= rfrm + FW'(1);
    end
  end

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frames_ready <= NW'(FRAMES));
  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> overflow);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R4
  commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (frames_ready != '0));
  // R10
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && drain) |=> $stable(frames_ready));
endmodule

// File: tb/descramble_fbuf_tb.sv
module descramble_fbuf_tb_top;
  localparam int FR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_en = 1'b0, map_we = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [5:0] map_idx = '0, map_val = '0;
  logic [15:0] in_data = '0;
  logic [2:0] in_adc = '0, in_chan = '0;
  logic out_valid, out_last, overflow;
  logic [15:0] out_data, drop_count;
  logic [4:0] frames_ready;

  always #2 clk = ~clk;

  descramble_fbuf #(.DW(16), .ADCS(8), .CHS(8), .FRAMES(FR), .DCW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .map_we(map_we),
    .map_idx(map_idx), .map_val(map_val), .in_valid(in_valid),
    .in_data(in_data), .in_adc(in_adc), .in_chan(in_chan),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .frames_ready(frames_ready),
    .overflow(overflow), .drop_count(drop_count));

  int checks = 0, errors = 0;
  int bmap [64];
  logic [16:0] exp_q [$];
  string tag = "R3";
  bit toggle_en = 0, stream_watch = 0, done = 0;
  int stream_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] val(input int seed, input int p);
    return 16'(seed * 977 + p * 131 + 7);
  endfunction

  task automatic expect_frame(input int seed);
    int e [64];
    for (int p = 0; p < 64; p++) e[bmap[p]] = val(seed, p);
    for (int s = 0; s < 64; s++) exp_q.push_back({s == 63, 16'(e[s])});
  endtask

  task automatic drive(input int p, input logic [15:0] d);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d;
    in_adc = 3'(p / 8); in_chan = 3'(p % 8);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int seed, input bit keep);
    if (keep) expect_frame(seed);
    for (int p = 0; p < 64; p++) drive(p, val(seed, p));
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  logic stall_prev = 1'b0;
  logic [16:0] held;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stall_prev) check(out_valid && {out_last, out_data} == held, "R6",
                            {out_last, out_data}, held);
      stall_prev = out_valid && !out_ready;
      held = {out_last, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", out_data, -1);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check(out_data == e[15:0], tag, out_data, e[15:0]);
          check(out_last == e[16], "R5", out_last, e[16]);
        end
      end
      if (stream_watch && (frames_ready > 1 || overflow)) stream_bad++;
    end
  end

  // out_ready pattern driver
  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #1;
      if (toggle_en) begin
        out_ready = (n % 3) != 0;
        n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) bmap[i] = i;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(frames_ready == 0, "R1 frames_ready", frames_ready, 0);
    check(overflow == 0, "R1 overflow", overflow, 0);
    check(drop_count == 0, "R1 drop_count", drop_count, 0);

    // R4 with identity map (R1), reader stalled
    tag = "R1 identity";
    acq_en = 1'b1;
    expect_frame(1);
    for (int p = 0; p < 63; p++) drive(p, val(1, p));
    idle(); @(negedge clk);
    check(frames_ready == 0, "R4 before last", frames_ready, 0);
    drive(63, val(1, 63));
    idle(); @(negedge clk);
    check(frames_ready == 1, "R4 after last", frames_ready, 1);
    out_ready = 1'b1;
    wait_drain();
    check(frames_ready == 0, "R7 drained", frames_ready, 0);

    // R2/R3 programmed permutation
    acq_en = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1;
      map_we = 1'b1; map_idx = 6'(i); map_val = 6'((i * 5 + 3) % 64);
      bmap[i] = (i * 5 + 3) % 64;
    end
    @(posedge clk); #1; map_we = 1'b0;
    tag = "R3 remap";
    acq_en = 1'b1;
    send_frame(2, 1);
    idle();
    wait_drain();

    // R2 write while acquiring is ignored
    @(posedge clk); #1;
    map_we = 1'b1; map_idx = 6'd0; map_val = 6'd40;
    @(posedge clk); #1; map_we = 1'b0;
    tag = "R2 write ignored";
    send_frame(3, 1);
    idle();
    wait_drain();

    // R9 disabled input ignored, partial frame abandoned
    out_ready = 1'b0;
    acq_en = 1'b0;
    for (int p = 0; p < 5; p++) drive(p, 16'hDEAD);
    idle();
    acq_en = 1'b1;
    for (int p = 0; p < 20; p++) drive(p, 16'hBEEF);
    idle();
    acq_en = 1'b0;
    @(posedge clk); #1; acq_en = 1'b1;
    tag = "R9 restart";
    send_frame(4, 1);
    idle(); @(negedge clk);
    check(frames_ready == 1, "R9 one frame", frames_ready, 1);
    out_ready = 1'b1;
    wait_drain();

    // R6 stalls while frames arrive
    tag = "R6 stall data";
    toggle_en = 1;
    for (int f = 0; f < 3; f++) send_frame(10 + f, 1);
    idle();
    wait_drain();
    toggle_en = 0;
    @(posedge clk); #1; out_ready = 1'b1;

    // R10 back-to-back commit and drain
    tag = "R10 stream";
    stream_watch = 1;
    for (int f = 0; f < 5; f++) send_frame(20 + f, 1);
    idle();
    wait_drain();
    stream_watch = 0;
    check(stream_bad == 0, "R10 coincidence", stream_bad, 0);
    check(drop_count == 0, "R10 no drop", drop_count, 0);

    // R8 overflow with reader stalled
    out_ready = 1'b0;
    tag = "R7 ring order";
    for (int f = 0; f < FR + 2; f++) send_frame(40 + f, f < FR);
    idle(); @(negedge clk);
    check(frames_ready == FR, "R7 ring full", frames_ready, FR);
    check(overflow == 1, "R8 overflow", overflow, 1);
    check(drop_count == 2, "R8 drop_count", drop_count, 2);
    out_ready = 1'b1;
    wait_drain();
    check(frames_ready == 0, "R8 drained", frames_ready, 0);
    tag = "R8 resume";
    send_frame(90, 1);
    idle();
    wait_drain();
    check(overflow == 1, "R8 sticky", overflow, 1);
    check(drop_count == 2, "R8 count held", drop_count, 2);
    check(exp_q.size() == 0, "R7 all words seen", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule